// File: doc/BRIEF.md
# Row-Colored Character Overlay Generator

This block draws a text overlay on a raster video signal. Text lives in a grid of eight rows by twenty columns; each grid cell holds an 8-bit character code. For every displayed dot the block looks up the glyph row of the current character in an external font ROM. Each glyph is 11 dots wide by 15 lines tall. It picks one dot of that row, most significant bit first, and drives red, green and blue levels plus a keying line. Downstream mixing uses the keying line to replace the incoming picture with the overlay color.

Color belongs to a whole text row. Each row has its own 3-bit color, and a row whose color is zero shows nothing. One fixed row (parameter `BAR_ROW`) can be drawn in two colors. Cells to the left of a programmable split column take the row's own color, and cells at or right of the split take a second bar color, so a row of solid glyphs reads as a level meter. The software side writes character codes, colors, the split column and the display origin through a simple write port. These values sit in a shadow copy and move to the displayed copy on the next VSYNC rising edge.

`clk` is the dot clock. All horizontal counting stops while HSYNC is high and restarts from a fixed phase when HSYNC falls, so every line begins identically. A five-state sequencer runs each line. ST_WAIT holds after reset until the first VSYNC edge, then moves to ST_TAIL. ST_TAIL moves to ST_HSYNC when HSYNC rises. ST_HSYNC moves to ST_LEAD when HSYNC falls. ST_LEAD counts the horizontal origin and moves to ST_ACTIVE when the count matches it. ST_ACTIVE walks the 220 cell dots and moves to ST_TAIL after the last one. A rising HSYNC in ST_LEAD or ST_ACTIVE returns the sequencer to ST_HSYNC at once.

Top module: `osd_row_color_gen`

## Requirements
- R1: While reset is asserted and right after it, `vid_blank`, `vid_r`, `vid_g` and `vid_b` are all 0.
- R2: `vid_blank` is 1 only on a dot inside the grid whose glyph bit is 1 and whose cell color is nonzero. Everywhere else `vid_blank` is 0 and all three color outputs are 0.
- R3: On a keyed dot, `{vid_r,vid_g,vid_b}` equals the row's 3-bit color. The color register bit 2 is red, bit 1 is green and bit 0 is blue. Row colors sit at write addresses 160+row.
- R4: A row whose selected color is 0 produces no keyed dots at all.
- R5: In row `BAR_ROW` (default 7), cells with column < split take the row color and cells with column >= split take the bar color. The bar color is at address 168 and the split column at address 169, so split 0 makes the whole row the bar color and split 20 makes none of it.
- R6: Line L counts HSYNC falling edges after the VSYNC rise, starting at 0. Grid line 0 is line L = V, where V is the vertical origin at address 170. With H the horizontal origin at address 171 and E0 the clock edge that first samples HSYNC low, cell column c, dot d is output after edge E0+3+H+11c+d. No dot outside the 120 grid lines or the 220 cell dots is keyed.
- R7: During the dot for cell (row, column) at line-in-cell n, `rom_addr` = code*15 + n, where code is the character at write address row*20+column. `rom_data` is taken one clock later, and its bit 10 is shown first, at cell dot 0.
- R8: Writes to any address (character codes 0..159, colors, split, origins) change the displayed content only from the next VSYNC rising edge on.
- R9: While HSYNC is high no dot is keyed and the dot counting is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hsync | input | 1 | Horizontal sync, active high |
| vsync | input | 1 | Vertical sync, active high |
| cpu_we | input | 1 | Write strobe for the shadow registers |
| cpu_addr | input | 8 | Write address: 0..159 codes, 160..167 row colors, 168 bar color, 169 split, 170 vertical origin, 171 horizontal origin |
| cpu_wdata | input | 8 | Write data |
| rom_addr | output | 12 | Font ROM word address |
| rom_data | input | 11 | Font ROM word, returned one clock after the address |
| vid_r | output | 1 | Red level |
| vid_g | output | 1 | Green level |
| vid_b | output | 1 | Blue level |
| vid_blank | output | 1 | Overlay key, high where overlay replaces video |

## Verification
Directed frames pin down the corners. One frame has both origins at zero, code 255 in the first cell, one row colored zero and split 0. Another has the largest origins, a zero-colored row and split 20. Together they separate a bar-split off-by-one error, an origin miscount and a wrong ROM index at the top of the code range. Random frames mix random codes, colors, split columns and origins, and separate wrong dot order within a glyph word, wrong row-to-color mapping and a lost line-in-cell wrap. Writes made in the middle of each frame show whether the displayed content tears before the next VSYNC.

// File: rtl/osd_pkg.sv
package osd_pkg;
    typedef enum logic [2:0] {
        ST_WAIT,
        ST_HSYNC,
        ST_LEAD,
        ST_ACTIVE,
        ST_TAIL
    } osd_state_t;

    typedef logic [2:0] rgb_t;
endpackage

// File: rtl/osd_regfile.sv
module osd_regfile #(
    parameter int ROWS   = 8,
    parameter int COLS   = 20,
    parameter int CODE_W = 8,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 8,
    localparam int CELLS = ROWS * COLS,
    localparam int IDX_W = $clog2(CELLS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic                 commit,
    input  logic [IDX_W-1:0]     rd_idx,
    output logic [CODE_W-1:0]    rd_code,
    output logic [ROWS*3-1:0]    act_color,
    output osd_pkg::rgb_t        act_bar_b,
    output logic [DATA_W-1:0]    act_split,
    output logic [DATA_W-1:0]    act_vorg,
    output logic [DATA_W-1:0]    act_horg
);
    localparam int A_COLOR = CELLS;
    localparam int A_BAR   = CELLS + ROWS;
    localparam int A_SPLIT = A_BAR + 1;
    localparam int A_VORG  = A_BAR + 2;
    localparam int A_HORG  = A_BAR + 3;

    logic [CODE_W-1:0]  sh_ram  [CELLS];
    logic [CODE_W-1:0]  act_ram [CELLS];
    osd_pkg::rgb_t      sh_col  [ROWS];
    osd_pkg::rgb_t      act_col [ROWS];
    osd_pkg::rgb_t      sh_bar_b;
    logic [DATA_W-1:0]  sh_split, sh_vorg, sh_horg;

    // Shadow copy: written by software at any time
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < CELLS; i++) sh_ram[i] <= '0;
            for (int r = 0; r < ROWS; r++)  sh_col[r] <= '0;
            sh_bar_b <= '0;
            sh_split <= '0;
            sh_vorg  <= '0;
            sh_horg  <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < CELLS; i++)
                if (wr_addr == ADDR_W'(i)) sh_ram[i] <= wr_data[CODE_W-1:0];
            for (int r = 0; r < ROWS; r++)
                if (wr_addr == ADDR_W'(A_COLOR + r)) sh_col[r] <= wr_data[2:0];
            if (wr_addr == ADDR_W'(A_BAR))   sh_bar_b <= wr_data[2:0];
            if (wr_addr == ADDR_W'(A_SPLIT)) sh_split <= wr_data;
            if (wr_addr == ADDR_W'(A_VORG))  sh_vorg  <= wr_data;
            if (wr_addr == ADDR_W'(A_HORG))  sh_horg  <= wr_data;
        end
    end

    // Displayed copy: follows the shadow only on a frame boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < CELLS; i++) act_ram[i] <= '0;
            for (int r = 0; r < ROWS; r++)  act_col[r] <= '0;
            act_bar_b <= '0;
            act_split <= '0;
            act_vorg  <= '0;
            act_horg  <= '0;
        end else if (commit) begin
            for (int i = 0; i < CELLS; i++) act_ram[i] <= sh_ram[i];
            for (int r = 0; r < ROWS; r++)  act_col[r] <= sh_col[r];
            act_bar_b <= sh_bar_b;
            act_split <= sh_split;
            act_vorg  <= sh_vorg;
            act_horg  <= sh_horg;
        end
    end

    assign rd_code = act_ram[rd_idx];

    for (genvar r = 0; r < ROWS; r++) begin : g_color_flat
        assign act_color[r*3 +: 3] = act_col[r];
    end

    AST_SPLIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(act_split)) else $error("split changed without vsync"); // R8
    AST_ORIGIN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> ($stable(act_vorg) && $stable(act_horg))) else $error("origin changed without vsync"); // R8
endmodule

// File: rtl/osd_timing.sv
module osd_timing #(
    parameter int ROWS   = 8,
    parameter int COLS   = 20,
    parameter int CELL_W = 11,
    parameter int CELL_H = 15,
    parameter int DATA_W = 8,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int COL_W  = $clog2(COLS),
    localparam int DOT_W  = $clog2(CELL_W),
    localparam int LIC_W  = $clog2(CELL_H),
    localparam int LINE_W = DATA_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync,
    input  logic              vsync,
    input  logic [DATA_W-1:0] v_org,
    input  logic [DATA_W-1:0] h_org,
    output logic              commit,
    output logic              cell_valid,
    output logic [ROW_W-1:0]  row,
    output logic [LIC_W-1:0]  lic,
    output logic [COL_W-1:0]  col,
    output logic [DOT_W-1:0]  dot
);
    import osd_pkg::*;

    osd_state_t        state, nxt;
    logic              hs_q, vs_q;
    logic              hs_rise, hs_fall, vs_rise;
    logic [DATA_W-1:0] hcnt;
    logic [LINE_W-1:0] line_no;
    logic              vact;
    logic              last_dot;

    assign hs_rise  = hsync & ~hs_q;
    assign hs_fall  = ~hsync & hs_q;
    assign vs_rise  = vsync & ~vs_q;
    assign last_dot = (col == COL_W'(COLS - 1)) && (dot == DOT_W'(CELL_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= 1'b0;
            vs_q <= 1'b0;
        end else begin
            hs_q <= hsync;
            vs_q <= vsync;
        end
    end

    // Line sequencer
    always_comb begin
        nxt = state;
        unique case (state)
            ST_WAIT:   if (vs_rise) nxt = ST_TAIL;
            ST_HSYNC:  if (hs_fall) nxt = ST_LEAD;
            ST_LEAD:   if (hs_rise) nxt = ST_HSYNC;
                       else if (hcnt == h_org) nxt = ST_ACTIVE;
            ST_ACTIVE: if (hs_rise) nxt = ST_HSYNC;
                       else if (last_dot) nxt = ST_TAIL;
            ST_TAIL:   if (hs_rise) nxt = ST_HSYNC;
            default:   nxt = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_WAIT;
        else        state <= nxt;
    end

    // Horizontal counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt <= '0;
            col  <= '0;
            dot  <= '0;
        end else begin
            hcnt <= (state == ST_LEAD) ? hcnt + 1'b1 : '0;
            if (state != ST_ACTIVE) begin
                col <= '0;
                dot <= '0;
            end else if (dot == DOT_W'(CELL_W - 1)) begin
                dot <= '0;
                col <= col + 1'b1;
            end else begin
                dot <= dot + 1'b1;
            end
        end
    end

    // Vertical counters: line number, grid row, line within cell
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_no <= '0;
            vact    <= 1'b0;
            row     <= '0;
            lic     <= '0;
        end else if (vs_rise) begin
            line_no <= '0;
            vact    <= 1'b0;
            row     <= '0;
            lic     <= '0;
        end else if (hs_fall && state != ST_WAIT) begin
            if (line_no != '1) line_no <= line_no + 1'b1;
            if (line_no == {1'b0, v_org}) begin
                vact <= 1'b1;
                row  <= '0;
                lic  <= '0;
            end else if (vact) begin
                if (lic == LIC_W'(CELL_H - 1)) begin
                    lic <= '0;
                    if (row == ROW_W'(ROWS - 1)) vact <= 1'b0;
                    else                         row  <= row + 1'b1;
                end else begin
                    lic <= lic + 1'b1;
                end
            end
        end
    end

    // Outputs
    always_comb begin
        commit     = vs_rise;
        cell_valid = (state == ST_ACTIVE) && vact;
    end

    AST_SYNC_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_rise && state != ST_WAIT) |=> (state == ST_HSYNC)) else $error("dots ran into hsync"); // R9
    AST_HSYNC_DARK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HSYNC) |-> !cell_valid) else $error("cell valid during sync"); // R9
    AST_LEAD_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE && $past(state) == ST_LEAD) |-> ($past(hcnt) == h_org)) else $error("lead length wrong"); // R6
    AST_CELL_BOUNDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ACTIVE) |-> (col < COL_W'(COLS))) else $error("column overrun"); // R6
endmodule

// File: rtl/osd_pixel.sv
module osd_pixel #(
    parameter int ROWS    = 8,
    parameter int COLS    = 20,
    parameter int CELL_W  = 11,
    parameter int DATA_W  = 8,
    parameter int BAR_ROW = 7,
    localparam int ROW_W  = $clog2(ROWS),
    localparam int COL_W  = $clog2(COLS),
    localparam int DOT_W  = $clog2(CELL_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cell_valid,
    input  logic [ROW_W-1:0]    row,
    input  logic [COL_W-1:0]    col,
    input  logic [DOT_W-1:0]    dot,
    input  logic [ROWS*3-1:0]   color_flat,
    input  osd_pkg::rgb_t       bar_b,
    input  logic [DATA_W-1:0]   split,
    input  logic [CELL_W-1:0]   rom_data,
    output osd_pkg::rgb_t       vid_rgb,
    output logic                vid_blank
);
    osd_pkg::rgb_t     row_color, sel_color, color1;
    logic              v1, pix_bit;
    logic [DOT_W-1:0]  dot1;

    // Stage 0: pick the cell color (row color, or the bar color right of the split)
    always_comb begin
        row_color = color_flat[int'(row)*3 +: 3];
        if (row == ROW_W'(BAR_ROW) && DATA_W'(col) >= split) sel_color = bar_b;
        else                                                 sel_color = row_color;
    end

    // Stage 1: align with the font word returning from the ROM
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1     <= 1'b0;
            dot1   <= '0;
            color1 <= '0;
        end else begin
            v1     <= cell_valid;
            dot1   <= dot;
            color1 <= sel_color;
        end
    end

    assign pix_bit = rom_data[DOT_W'(CELL_W - 1) - dot1];

    // Stage 2: registered video outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vid_blank <= 1'b0;
            vid_rgb   <= '0;
        end else begin
            vid_blank <= v1 && pix_bit && (color1 != '0);
            vid_rgb   <= (v1 && pix_bit) ? color1 : '0;
        end
    end

    AST_KEY_HAS_COLOR: assert property (@(posedge clk) disable iff (!rst_n)
        vid_blank |-> (vid_rgb != '0)) else $error("keyed dot with zero color"); // R4
    AST_DARK_UNKEYED: assert property (@(posedge clk) disable iff (!rst_n)
        !vid_blank |-> (vid_rgb == '0)) else $error("color outside key"); // R2
    AST_NO_KEY_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !v1 |=> !vid_blank) else $error("key outside grid"); // R2
endmodule

// File: rtl/osd_row_color_gen.sv
module osd_row_color_gen #(
    parameter int ROWS    = 8,
    parameter int COLS    = 20,
    parameter int CELL_W  = 11,
    parameter int CELL_H  = 15,
    parameter int CODE_W  = 8,
    parameter int DATA_W  = 8,
    parameter int BAR_ROW = 7,
    localparam int CELLS  = ROWS * COLS,
    localparam int ADDR_W = $clog2(CELLS + ROWS + 4),
    localparam int ROM_AW = $clog2((1 << CODE_W) * CELL_H)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsync,
    input  logic              vsync,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [ROM_AW-1:0] rom_addr,
    input  logic [CELL_W-1:0] rom_data,
    output logic              vid_r,
    output logic              vid_g,
    output logic              vid_b,
    output logic              vid_blank
);
    localparam int IDX_W = $clog2(CELLS);
    localparam int ROW_W = $clog2(ROWS);
    localparam int COL_W = $clog2(COLS);
    localparam int DOT_W = $clog2(CELL_W);
    localparam int LIC_W = $clog2(CELL_H);

    logic              commit, cell_valid;
    logic [ROW_W-1:0]  row;
    logic [LIC_W-1:0]  lic;
    logic [COL_W-1:0]  col;
    logic [DOT_W-1:0]  dot;
    logic [IDX_W-1:0]  rd_idx;
    logic [CODE_W-1:0] rd_code;
    logic [ROWS*3-1:0] act_color;
    osd_pkg::rgb_t     act_bar_b, vid_rgb;
    logic [DATA_W-1:0] act_split, act_vorg, act_horg;

    osd_regfile #(
        .ROWS(ROWS), .COLS(COLS), .CODE_W(CODE_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(cpu_we), .wr_addr(cpu_addr), .wr_data(cpu_wdata),
        .commit(commit),
        .rd_idx(rd_idx), .rd_code(rd_code),
        .act_color(act_color), .act_bar_b(act_bar_b), .act_split(act_split),
        .act_vorg(act_vorg), .act_horg(act_horg)
    );

    osd_timing #(
        .ROWS(ROWS), .COLS(COLS), .CELL_W(CELL_W), .CELL_H(CELL_H), .DATA_W(DATA_W)
    ) u_timing (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .v_org(act_vorg), .h_org(act_horg),
        .commit(commit), .cell_valid(cell_valid),
        .row(row), .lic(lic), .col(col), .dot(dot)
    );

    assign rd_idx   = IDX_W'(row) * IDX_W'(COLS) + IDX_W'(col);
    assign rom_addr = ROM_AW'(rd_code) * ROM_AW'(CELL_H) + ROM_AW'(lic);

    osd_pixel #(
        .ROWS(ROWS), .COLS(COLS), .CELL_W(CELL_W), .DATA_W(DATA_W), .BAR_ROW(BAR_ROW)
    ) u_pixel (
        .clk(clk), .rst_n(rst_n), .cell_valid(cell_valid),
        .row(row), .col(col), .dot(dot),
        .color_flat(act_color), .bar_b(act_bar_b), .split(act_split),
        .rom_data(rom_data), .vid_rgb(vid_rgb), .vid_blank(vid_blank)
    );

    assign vid_r = vid_rgb[2];
    assign vid_g = vid_rgb[1];
    assign vid_b = vid_rgb[0];
endmodule

// File: tb/osd_row_color_gen_bench.sv
module osd_row_color_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NCELL = 160;
    localparam int LINE_DOTS = 256;
    localparam int MID_LINE = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsync = 1'b0, vsync = 1'b0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0, cpu_wdata = '0;
    logic [11:0] rom_addr;
    logic [10:0] rom_data;
    logic        vid_r, vid_g, vid_b, vid_blank;

    int n_chk = 0, n_bad = 0;
    int sh_code[NCELL], act_code[NCELL];
    int sh_col[8], act_col[8];
    int sh_barb = 0, act_barb = 0, sh_split = 0, act_split = 0;
    int sh_vorg = 0, act_vorg = 0, sh_horg = 0, act_horg = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    osd_row_color_gen u_osd_row_color_gen (
        .clk(clk), .rst_n(rst_n), .hsync(hsync), .vsync(vsync),
        .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .rom_addr(rom_addr), .rom_data(rom_data),
        .vid_r(vid_r), .vid_g(vid_g), .vid_b(vid_b), .vid_blank(vid_blank)
    );

    // Font ROM content: a fixed scrambled pattern, one-clock read latency
    function automatic logic [10:0] glyph(input int a);
        logic [31:0] v;
        v = 32'(a) * 32'd40503 ^ (32'(a) << 5) ^ 32'h3A5;
        return v[18:8];
    endfunction

    always_ff @(posedge clk) rom_data <= glyph(int'(rom_addr));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input int a, input int d);
        cpu_we = 1'b1; cpu_addr = 8'(a); cpu_wdata = 8'(d);
        tick();
        cpu_we = 1'b0;
        if (a < NCELL)       sh_code[a] = d;
        else if (a < 168)    sh_col[a-NCELL] = d & 7;
        else if (a == 168)   sh_barb = d & 7;
        else if (a == 169)   sh_split = d;
        else if (a == 170)   sh_vorg = d;
        else if (a == 171)   sh_horg = d;
    endtask

    task automatic pulse_vsync();
        vsync = 1'b1;
        tick(); tick();
        vsync = 1'b0;
        act_code = sh_code; act_col = sh_col;
        act_barb = sh_barb; act_split = sh_split;
        act_vorg = sh_vorg; act_horg = sh_horg;
        tick();
    endtask

    task automatic run_line(input int L);
        bit in_v;
        int r, n;
        in_v = (L >= act_vorg) && (L < act_vorg + 120);
        r = in_v ? (L - act_vorg) / 15 : 0;
        n = in_v ? (L - act_vorg) % 15 : 0;
        hsync = 1'b0;
        for (int k = 0; k < LINE_DOTS; k++) begin
            int p, q, eb, er, got;
            string tag;
            tick();
            p = k - 3 - act_horg;
            q = k - 1 - act_horg;
            eb = 0; er = 0; tag = "R6";
            if (in_v && p >= 0 && p < 220) begin
                int c, d, cl, w;
                c = p / 11; d = p % 11;
                w = int'(glyph(act_code[r*20+c] * 15 + n));
                cl = (r == 7 && c >= act_split) ? act_barb : act_col[r];
                eb = (((w >> (10 - d)) & 1) == 1 && cl != 0) ? 1 : 0;
                er = eb ? cl : 0;
                if (cl == 0)            tag = "R4";
                else if (r == 7)        tag = "R5";
                else if (L >= MID_LINE) tag = "R8";
                else if (eb != 0)       tag = "R3";
                else                    tag = "R2";
            end
            got = {vid_blank, vid_r, vid_g, vid_b};
            chk(got == ((eb << 3) | er), tag, got, (eb << 3) | er);
            if (in_v && q >= 0 && q < 220) begin
                int ea;
                ea = act_code[r*20 + q/11] * 15 + n;
                chk(int'(rom_addr) == ea, "R7", int'(rom_addr), ea);
            end
        end
    endtask

    task automatic sync_gap(input bit do_writes);
        hsync = 1'b1;
        for (int k = 0; k < 4; k++) begin
            tick();
            chk({vid_blank, vid_r, vid_g, vid_b} == 4'b0, "R9",
                {vid_blank, vid_r, vid_g, vid_b}, 0);
        end
        if (do_writes)
            for (int k = 0; k < 16; k++) wr($urandom_range(171, 0), $urandom_range(255, 0));
    endtask

    task automatic run_frame();
        int nl;
        pulse_vsync();
        nl = act_vorg + 121;
        for (int L = 0; L < nl; L++) begin
            sync_gap(L == MID_LINE);
            run_line(L);
        end
    endtask

    task automatic load_random();
        for (int i = 0; i < NCELL; i++) wr(i, $urandom_range(255, 0));
        for (int r = 0; r < 8; r++) wr(NCELL + r, $urandom_range(7, 0));
        wr(168, $urandom_range(7, 1));
        wr(169, $urandom_range(20, 0));
        wr(170, $urandom_range(4, 0));
        wr(171, $urandom_range(28, 0));
    endtask

    initial begin
        void'($urandom(32'd4417));
        for (int i = 0; i < NCELL; i++) begin sh_code[i] = 0; act_code[i] = 0; end
        for (int r = 0; r < 8; r++) begin sh_col[r] = 0; act_col[r] = 0; end
        @(negedge clk);
        chk({vid_blank, vid_r, vid_g, vid_b} == 4'b0, "R1", {vid_blank, vid_r, vid_g, vid_b}, 0);
        tick(); tick();
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            tick();
            chk({vid_blank, vid_r, vid_g, vid_b} == 4'b0, "R1", {vid_blank, vid_r, vid_g, vid_b}, 0);
        end

        // Frame A: zero origins, code 255 top-left, row 0 off, whole bar row in bar color (R4, R5, R6, R7)
        load_random();
        wr(0, 255); wr(159, 0);
        for (int r = 0; r < 8; r++) wr(NCELL + r, r);
        wr(168, 2); wr(169, 0); wr(170, 0); wr(171, 0);
        run_frame();

        // Frame B: largest origins, bar row entirely row color, row 5 off (R5, R6)
        load_random();
        for (int r = 0; r < 8; r++) wr(NCELL + r, (r == 5) ? 0 : $urandom_range(7, 1));
        wr(168, 5); wr(169, 20); wr(170, 4); wr(171, 28);
        run_frame();

        // Frames C and D: random content, split mid row (R2, R3, R5, R8)
        load_random();
        wr(169, 7);
        run_frame();
        load_random();
        run_frame();

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        n_bad++;
        $display("FAIL R6 watchdog expired act=0 exp=1");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule